// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block latches the value of a 32-bit free-running time counter at the moment a chosen event occurs. The event comes either from an asynchronous event-request pin, which is resynchronised inside the block, or from an internal periodic trigger that is already in the block's clock domain. The host picks the source and the active edge.

A small register interface with four word addresses holds the capture settings and a status word. The status word carries a valid flag, a sticky missed-capture flag and a saturating count of accepted captures. The captured count is read back as two 16-bit halves. The host takes a timestamp by reading the status word and then the two halves. It then writes the status word with the valid bit at zero, which frees the channel for the next capture. There is a single capture channel.

Top module: `evcap_unit`

## Requirements
- R1: After reset, all four register words (address 0 settings, 1 status, 2 timestamp low, 3 timestamp high) read zero.
- R2: With the external source selected (status bit 0 = 0), the enable pin high and rising-edge mode (settings bit 0 = 0), a rising edge on the event pin stores `time_cnt` as seen two cycles after the pin is first sampled high. It also sets the status valid flag (bit 1).
- R3: With settings bit 0 = 1, captures happen on falling edges of the selected source and rising edges are ignored.
- R4: Status bit 0 = 1 selects the internal trigger as the source. Edges on the external pin then do not capture.
- R5: With overwrite off (settings bit 1 = 0), an event while valid is set keeps the stored timestamp and sets the error flag (status bit 2). The error flag stays set until a status write with bit 2 = 0. A status write clears valid or error only where the written bit is 0.
- R6: With overwrite on (settings bit 1 = 1), an event while valid is set replaces the stored timestamp and does not raise the error flag.
- R7: The sequence count (status bits 15:8) increments once for each accepted capture when the run bit (settings bit 2) is 1. It holds when the run bit is 0.
- R8: Any write to the settings word or the status word clears the sequence count to zero. A settings write leaves the valid flag unchanged.
- R9: The sequence count saturates at its maximum (255 for the default width) and does not wrap.
- R10: While the enable pin is low, the external source produces no capture.
- R11: Address 2 returns the low 16 bits and address 3 the high 16 bits of the stored timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_cnt | input | 32 | Free-running time counter to sample |
| evt_pin | input | 1 | Asynchronous external event request |
| pin_en | input | 1 | Enables the external event pin |
| tick_int | input | 1 | Internal periodic trigger, synchronous |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |

## Verification
A wrong valid or error flag shows at the status word on the first read after the event. That read comes two cycles after an internal trigger edge, or four cycles after an external pin edge because of the synchroniser. A corrupted sequence count shows at the same read. A counter that wraps instead of holding is only exposed after 256 accepted captures, so the bench drives that many. A timestamp that is overwritten when it should be held shows as a wrong low word once a second event has arrived.

// File: rtl/evcap_pkg.sv
// Package: shared register map and field positions for the event capture unit.
// Assumes a 2-bit word address and a 16-bit data path.
package evcap_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_SETUP = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_TS_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_TS_HI = 2'd3;

    // settings word
    localparam int B_FALL = 0;
    localparam int B_OVWR = 1;
    localparam int B_RUN  = 2;
    // status word
    localparam int B_SRC  = 0;
    localparam int B_VLD  = 1;
    localparam int B_ERR  = 2;
    localparam int SEQ_LSB = 8;

    typedef struct packed {
        logic run;
        logic ovwr;
        logic fall;
    } setup_t;
endpackage

// File: rtl/evcap_sync.sv
// Module: multi-stage synchroniser for an asynchronous level.
// Assumes STAGES >= 2; output is the last stage.
module evcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // shift one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else if (gi == 0) chain[gi] <= d_async;
                else chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/evcap_trig.sv
// Module: source selection, polarity and edge detection.
// Produces a one-cycle event pulse. Assumes tick_int is already synchronous.
module evcap_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_pin,
    input  logic pin_en,
    input  logic tick_int,
    input  logic use_int,
    input  logic fall,
    output logic evt
);
    logic pin_s;
    logic lvl;
    logic lvl_d;
    logic rise_e;
    logic fall_e;

    evcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(evt_pin),
        .q_sync (pin_s)
    );

    assign lvl = use_int ? tick_int : pin_s;

    // remember the previous level of the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else lvl_d <= lvl;
    end

    // edge pick and pin gating
    always_comb begin
        rise_e = lvl & ~lvl_d;
        fall_e = ~lvl & lvl_d;
        evt    = (fall ? fall_e : rise_e) & (use_int | pin_en);
    end

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_int && !pin_en) |-> !evt); // R10
endmodule

// File: rtl/evcap_core.sv
// Module: capture store, valid and error flags, sequence counter.
// Assumes at most one event pulse per cycle; writes apply before captures.
module evcap_core #(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [TS_W-1:0]  time_cnt,
    input  logic             ovwr,
    input  logic             run,
    input  logic             stat_wr,
    input  logic             wr_vld,
    input  logic             wr_err,
    input  logic             seq_clr,
    output logic             vld,
    output logic             err,
    output logic [TS_W-1:0]  ts,
    output logic [SEQ_W-1:0] seq
);
    localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};

    logic accept;
    logic miss;
    logic vld_n;
    logic err_n;

    // decide accept or miss and the next flag values
    always_comb begin
        accept = evt & (~vld | ovwr);
        miss   = evt & vld & ~ovwr;
        vld_n  = (stat_wr ? (vld & wr_vld) : vld) | accept;
        err_n  = (stat_wr ? (err & wr_err) : err) | miss;
    end

    // flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            err <= 1'b0;
        end else begin
            vld <= vld_n;
            err <= err_n;
        end
    end

    // timestamp store
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else if (accept) ts <= time_cnt;
    end

    // saturating sequence counter
    always_ff @(posedge clk) begin
        if (!rst_n) seq <= '0;
        else if (seq_clr) seq <= '0;
        else if (accept && run && seq != SEQ_MAX) seq <= seq + 1'b1;
    end

    AST_HOLD_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !ovwr && !stat_wr) |=> $stable(ts)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !stat_wr) |=> err); // R5
    AST_OVW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && ovwr && !stat_wr) |=> !err); // R6
    AST_SEQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> (seq == '0)); // R8
    AST_SEQ_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq == SEQ_MAX && !seq_clr) |=> (seq == SEQ_MAX)); // R9
    AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !seq_clr) |=> $stable(seq)); // R7
endmodule

// File: rtl/evcap_unit.sv
// Module: top of the timestamp event capture unit.
// Holds the settings and source registers, decodes writes, muxes reads.
// Assumes SEQ_W <= 8 so the count fits in status bits 15:8.
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int SEQ_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_cnt,
    input  logic              evt_pin,
    input  logic              pin_en,
    input  logic              tick_int,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    setup_t           setup_q;
    logic             use_int;
    logic             evt;
    logic             setup_wr;
    logic             stat_wr;
    logic             vld;
    logic             err;
    logic [TS_W-1:0]  ts;
    logic [SEQ_W-1:0] seq;

    assign setup_wr = reg_wr && (reg_addr == A_SETUP);
    assign stat_wr  = reg_wr && (reg_addr == A_STAT);

    // settings and source-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            use_int <= 1'b0;
        end else begin
            if (setup_wr) begin
                setup_q.fall <= reg_wdata[B_FALL];
                setup_q.ovwr <= reg_wdata[B_OVWR];
                setup_q.run  <= reg_wdata[B_RUN];
            end
            if (stat_wr) use_int <= reg_wdata[B_SRC];
        end
    end

    evcap_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_pin (evt_pin),
        .pin_en  (pin_en),
        .tick_int(tick_int),
        .use_int (use_int),
        .fall    (setup_q.fall),
        .evt     (evt)
    );

    evcap_core #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .time_cnt(time_cnt),
        .ovwr    (setup_q.ovwr),
        .run     (setup_q.run),
        .stat_wr (stat_wr),
        .wr_vld  (reg_wdata[B_VLD]),
        .wr_err  (reg_wdata[B_ERR]),
        .seq_clr (setup_wr | stat_wr),
        .vld     (vld),
        .err     (err),
        .ts      (ts),
        .seq     (seq)
    );

    // read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SETUP: begin
                reg_rdata[B_FALL] = setup_q.fall;
                reg_rdata[B_OVWR] = setup_q.ovwr;
                reg_rdata[B_RUN]  = setup_q.run;
            end
            A_STAT: begin
                reg_rdata[B_SRC] = use_int;
                reg_rdata[B_VLD] = vld;
                reg_rdata[B_ERR] = err;
                reg_rdata[SEQ_LSB +: SEQ_W] = seq;
            end
            A_TS_LO: reg_rdata = ts[DATA_W-1:0];
            default: reg_rdata = ts[2*DATA_W-1:DATA_W];
        endcase
    end

    AST_SETUP_KEEPS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && !evt && !stat_wr) |=> (vld == $past(vld))); // R8
endmodule

// File: tb/sim_evcap_unit.sv
module sim_evcap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] time_cnt = '0;
    logic        evt_pin = 1'b0;
    logic        pin_en = 1'b0;
    logic        tick_int = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evcap_unit u0 (
        .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt), .evt_pin(evt_pin),
        .pin_en(pin_en), .tick_int(tick_int), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // {use_int, fall, time}
    localparam logic [33:0] VECS [6] = '{
        {1'b0, 1'b0, 32'h1234_5678},
        {1'b0, 1'b1, 32'hDEAD_BEEF},
        {1'b1, 1'b0, 32'h0000_FFFF},
        {1'b1, 1'b1, 32'hFFFF_0000},
        {1'b0, 1'b0, 32'h8000_0001},
        {1'b1, 1'b0, 32'hA5A5_5A5A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // full pulse on the chosen source; only one of its two edges captures
    task automatic fire(input logic internal);
        @(negedge clk);
        if (internal) tick_int = 1'b1; else evt_pin = 1'b1;
        repeat (5) @(negedge clk);
        if (internal) tick_int = 1'b0; else evt_pin = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic quick_tick();
        @(negedge clk); tick_int = 1'b1;
        @(negedge clk); tick_int = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset word", {16'h0, d}, 32'h0);
        end
        pin_en = 1'b1;

        // vector table: R2 R3 R4 R11
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, {13'h0, 1'b1, 1'b0, VECS[i][32]});
            wr(2'd1, {15'h0, VECS[i][33]});
            time_cnt = VECS[i][31:0];
            fire(VECS[i][33]);
            rd(2'd1, d);
            check("R2/R3/R4 status after capture", {16'h0, d}, {16'h0, 8'd1, 5'd0, 1'b0, 1'b1, VECS[i][33]});
            rd(2'd2, d);
            check("R11 ts low", {16'h0, d}, {16'h0, VECS[i][15:0]});
            rd(2'd3, d);
            check("R11 ts high", {16'h0, d}, {16'h0, VECS[i][31:16]});
        end

        // R4: internal selected, external edge ignored
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'h0001);
        fire(1'b0);
        rd(2'd1, d);
        check("R4 pin ignored with internal source", {16'h0, d}, 32'h0001);

        // R10: pin disabled
        wr(2'd1, 16'h0000);
        pin_en = 1'b0;
        fire(1'b0);
        rd(2'd1, d);
        check("R10 disabled pin no capture", {16'h0, d}, 32'h0000);
        pin_en = 1'b1;

        // R5: no overwrite, second event is a miss
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'h0000);
        time_cnt = 32'h0000_1111; fire(1'b0);
        time_cnt = 32'h0000_2222; fire(1'b0);
        rd(2'd1, d);
        check("R5 miss sets error, seq 1", {16'h0, d}, 32'h0106);
        rd(2'd2, d);
        check("R5 stored ts held", {16'h0, d}, 32'h1111);
        wr(2'd1, 16'h0004);
        rd(2'd1, d);
        check("R5 error kept by writing 1, valid cleared", {16'h0, d}, 32'h0004);
        wr(2'd1, 16'h0000);
        rd(2'd1, d);
        check("R5 error cleared by writing 0", {16'h0, d}, 32'h0000);

        // R6: overwrite mode
        wr(2'd0, 16'h0006);
        time_cnt = 32'h0000_3333; fire(1'b0);
        time_cnt = 32'h0000_4444; fire(1'b0);
        rd(2'd1, d);
        check("R6 R7 no error, seq 2", {16'h0, d}, 32'h0202);
        rd(2'd2, d);
        check("R6 ts replaced", {16'h0, d}, 32'h4444);

        // R8: settings write clears count, keeps valid
        wr(2'd0, 16'h0002);
        rd(2'd1, d);
        check("R8 settings write clears seq", {16'h0, d}, 32'h0002);

        // R7: run bit off, capture does not count
        fire(1'b0);
        rd(2'd1, d);
        check("R7 run off no count", {16'h0, d}, 32'h0002);

        // R9: saturation with internal ticks in overwrite mode
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'h0001);
        for (int k = 0; k < 260; k++) quick_tick();
        repeat (2) @(negedge clk);
        rd(2'd1, d);
        check("R9 seq saturates at 255", {16'h0, d}, 32'hFF03);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule